// File: doc/BRIEF.md
# SPI Master with Whole-Frame Chip Select

This block drives an SPI bus as master. Each transfer is one multi-byte frame, and chip select stays asserted across the whole frame rather than being pulsed per byte. A command gives the frame length in bytes and a transfer mode. Transmit bytes arrive on a valid/ready stream, and each received byte leaves on a valid/ready output stream. The block counts completed SCK bits down from the frame length times eight. Chip select is released only after the last bit has been shifted out and the matching input bit has been sampled.

If a transmit byte is late, or the receive side has not taken the previous byte, the block holds SCK idle at the byte boundary and keeps chip select low. The frame is never split. After chip select is released, the block stays busy for a programmable number of clocks before it will take another command. This guarantees a minimum deselect time between back-to-back frames.

Top module: `frame_spi_master`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, and busy_o, done_o, rx_valid_o and tx_ready_o are all 0.
- R2: Once cs_n_o falls for a frame, it stays 0 without a break until the frame ends, even while SCK is stalled waiting for data. sck_o is 0 whenever cs_n_o is 1.
- R3: A frame of N bytes carries exactly 8*N rising SCK edges. cs_n_o rises only after the last of them, on the following falling SCK edge.
- R4: The bus uses SPI mode 0: SCK idles low, MISO is sampled and MOSI is presented for the rising edge, data is MSB first, and each SCK half period lasts div_i+1 clocks.
- R5: Each received byte appears on rx_data_o with rx_valid_o, and both are held until rx_ready_i. The next byte does not start while a byte is still pending.
- R6: With mode_i = 2 (receive only), MOSI is 0 for every bit and tx_ready_o is never asserted.
- R7: With mode_i = 1 (transmit only), received bytes are dropped and rx_valid_o never rises. Modes 0 and 3 both transmit and receive.
- R8: After the done pulse, busy_o stays 1 for exactly gap_i+1 cycles counting the done cycle, and cs_n_o stays 1 throughout that time.
- R9: busy_o is 1 in the same cycle that an accepted start_i is presented. done_o is a one-cycle pulse in the cycle in which cs_n_o first reads 1 after a frame.
- R10: A start_i with len_i = 0 is ignored: busy_o stays 0 and cs_n_o never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIVW | SCK half period minus one, in clocks |
| gap_i | input | GAPW | Deselect gap after a frame, in clocks |
| start_i | input | 1 | Frame command strobe, taken while idle |
| len_i | input | LENW | Frame length in bytes |
| mode_i | input | 2 | 0/3 full duplex, 1 transmit only, 2 receive only |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte taken |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Received byte taken |
| busy_o | output | 1 | Frame or gap in progress |
| done_o | output | 1 | One-cycle pulse at chip-select release |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
A five-byte full-duplex frame with no stalls sets the baseline bit order, bit count and release point. The same frame with one transmit byte held back for many cycles shows whether a late byte stalls SCK or opens a gap in chip select. Receive-only and transmit-only frames check whether the zero fill and the dropped input are kept apart from the full-duplex path. A frame whose receive side holds off shows that back-pressure stops the bus between bytes without losing data. Single-byte and zero-length commands, together with divider values of 0 to 3 and gap values of 0 to 5, cover the edges of the counters.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef enum logic [1:0] {
    XF_FULL    = 2'd0,
    XF_TX_ONLY = 2'd1,
    XF_RX_ONLY = 2'd2,
    XF_FULL_B  = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOAD = 3'd1,
    S_LOW  = 3'd2,
    S_HIGH = 3'd3,
    S_GAP  = 3'd4
  } fspi_state_e;
endpackage

// File: rtl/fspi_tick.sv
module fspi_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && div != '0) |=> !tick);
endmodule

// File: rtl/fspi_gap.sv
module fspi_gap #(
  parameter int GAPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [GAPW-1:0] gap,
  output logic            expired
);
  logic [GAPW-1:0] cnt;
  logic            act;

  assign expired = act && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      act <= 1'b1;
      cnt <= gap;
    end else if (act) begin
      if (cnt == '0) act <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R8
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt != '0 && !load) |=> act);
endmodule

// File: rtl/frame_spi_master.sv
module frame_spi_master
  import fspi_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int GAPW = 8,
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_i,
  input  logic [GAPW-1:0] gap_i,
  input  logic            start_i,
  input  logic [LENW-1:0] len_i,
  input  logic [1:0]      mode_i,
  input  logic [7:0]      tx_data_i,
  input  logic            tx_valid_i,
  output logic            tx_ready_o,
  output logic [7:0]      rx_data_o,
  output logic            rx_valid_o,
  input  logic            rx_ready_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            sck_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic            cs_n_o
);
  localparam int CNTW = LENW + 3;

  function automatic logic [CNTW-1:0] bits_of(input logic [LENW-1:0] nbytes);
    return {nbytes, 3'b000};
  endfunction

  fspi_state_e     st;
  xfer_mode_e      mode_q;
  logic [CNTW-1:0] bitcnt;
  logic [7:0]      txsh, rxsh, rx_data_q;
  logic            rx_valid_q, cs_n_q, sck_q, done_q;

  // named events
  logic start_acc, rx_room, need_tx, byte_go, bit_rise, bit_fall;
  logic byte_end, frame_end, tick, gap_exp, run;

  assign start_acc = (st == S_IDLE) && start_i && (len_i != '0);
  assign rx_room   = (mode_q == XF_TX_ONLY) || !rx_valid_q;
  assign need_tx   = (mode_q != XF_RX_ONLY);
  assign byte_go   = (st == S_LOAD) && rx_room && (!need_tx || tx_valid_i);
  assign run       = (st == S_LOW) || (st == S_HIGH);
  assign bit_rise  = (st == S_LOW) && tick;
  assign bit_fall  = (st == S_HIGH) && tick;
  assign byte_end  = bit_fall && (bitcnt[2:0] == 3'd0);
  assign frame_end = bit_fall && (bitcnt == '0);

  fspi_tick #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_i), .tick(tick)
  );

  fspi_gap #(.GAPW(GAPW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(frame_end), .gap(gap_i), .expired(gap_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= XF_FULL;
      bitcnt     <= '0;
      txsh       <= '0;
      rxsh       <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      cs_n_q     <= 1'b1;
      sck_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      case (st)
        S_IDLE: if (start_acc) begin
          st     <= S_LOAD;
          mode_q <= xfer_mode_e'(mode_i);
          bitcnt <= bits_of(len_i);
        end
        S_LOAD: if (byte_go) begin
          txsh   <= need_tx ? tx_data_i : 8'h00;
          cs_n_q <= 1'b0;
          st     <= S_LOW;
        end
        S_LOW: if (tick) begin
          sck_q  <= 1'b1;
          rxsh   <= {rxsh[6:0], miso_i};
          bitcnt <= bitcnt - 1'b1;
          st     <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          sck_q <= 1'b0;
          txsh  <= {txsh[6:0], 1'b0};
          if (byte_end && mode_q != XF_TX_ONLY) begin
            rx_data_q  <= rxsh;
            rx_valid_q <= 1'b1;
          end
          if (frame_end) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            st     <= S_GAP;
          end else if (byte_end) begin
            st <= S_LOAD;
          end else begin
            st <= S_LOW;
          end
        end
        S_GAP: if (gap_exp) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tx_ready_o = (st == S_LOAD) && need_tx && rx_room;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign busy_o     = (st != S_IDLE) || start_acc;
  assign done_o     = done_q;
  assign sck_o      = sck_q;
  assign mosi_o     = cs_n_q ? 1'b0 : txsh[7];
  assign cs_n_o     = cs_n_q;

  // R2
  cs_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && bitcnt != '0) |=> !cs_n_q);
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);
  // R3
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> $fell(sck_q));
  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_q && !rx_ready_i) |=> (rx_valid_q && $stable(rx_data_q)));
  // R6
  rx_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && mode_q == XF_RX_ONLY) |-> !mosi_o);
  // R7
  tx_only_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XF_TX_ONLY && bit_fall) |=> !$rose(rx_valid_q));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i && len_i == '0) |=> (st == S_IDLE && cs_n_q));
  // R4
  rise_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |=> sck_q);
endmodule

// File: tb/sim_frame_spi_master.sv
`timescale 1ns/1ps
module sim_frame_spi_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_i = 8'd0, gap_i = 8'd0, len_i = 8'd0, tx_data_i = 8'd0;
  logic [1:0] mode_i = 2'd0;
  logic start_i = 1'b0, tx_valid_i = 1'b0, rx_ready_i = 1'b1, miso_i = 1'b0;
  logic tx_ready_o, rx_valid_o, busy_o, done_o, sck_o, mosi_o, cs_n_o;
  logic [7:0] rx_data_o;

  always #4 clk = ~clk;

  frame_spi_master u0 (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .gap_i(gap_i), .start_i(start_i),
    .len_i(len_i), .mode_i(mode_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i), .busy_o(busy_o), .done_o(done_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference state kept by the bench
  logic [7:0] txb[$], misob[$], rx_got[$];
  bit mosi_bits[$];
  int exp_bits = 0, exp_div = 0;
  int rises, hi_len, hi_bad, cs_rises, cs_early, done_bad, idle_bad, dones;
  int busy_cnt, txr_seen, miso_idx;
  bit counting, frame_over, prev_cs = 1, prev_sck = 0;

  function automatic bit slave_bit(int k);
    if (k >= exp_bits) return 1'b0;
    return misob[k/8][7 - (k % 8)];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n_o) begin miso_idx = 0; miso_i = slave_bit(0); end
      if (!cs_n_o && !prev_sck && sck_o) begin rises++; mosi_bits.push_back(mosi_o); end
      if (sck_o) hi_len++;
      else if (prev_sck) begin
        if (hi_len != exp_div + 1) hi_bad++;
        hi_len = 0;
        miso_idx++;
        miso_i = slave_bit(miso_idx);
      end
      if (!prev_cs && cs_n_o) begin
        cs_rises++;
        if (rises != exp_bits) cs_early++;
        if (!done_o) done_bad++;
      end
      if (cs_n_o && sck_o) idle_bad++;
      if (done_o) begin dones++; counting = 1; busy_cnt = 0; end
      if (counting) begin
        if (busy_o) busy_cnt++;
        else begin counting = 0; frame_over = 1; end
      end
      if (rx_valid_o && rx_ready_i) rx_got.push_back(rx_data_o);
      if (tx_ready_o) txr_seen++;
      prev_cs = cs_n_o;
      prev_sck = sck_o;
    end
  end

  task automatic run_frame(int len, int md, int dv, int gp, int stall_byte,
                           int stall_cyc, int rx_hold, int seed);
    int mism;
    txb.delete(); misob.delete(); rx_got.delete(); mosi_bits.delete();
    for (int i = 0; i < len; i++) begin
      txb.push_back(i == 0 ? 8'h03 : 8'((i * 37 + seed) & 255));
      misob.push_back(8'((i * 91 + seed * 7 + 5) & 255) ^ 8'h5a);
    end
    exp_bits = len * 8; exp_div = dv;
    rises = 0; hi_len = 0; hi_bad = 0; cs_rises = 0; cs_early = 0; done_bad = 0;
    idle_bad = 0; dones = 0; busy_cnt = 0; txr_seen = 0; counting = 0; frame_over = 0;
    @(negedge clk);
    div_i = 8'(dv); gap_i = 8'(gp);
    start_i = 1; len_i = 8'(len); mode_i = 2'(md);
    #1 chk(busy_o == 1, "R9 busy with start", int'(busy_o), 1);
    @(negedge clk);
    start_i = 0;
    fork
      begin
        if (md != 2) begin
          for (int i = 0; i < len; i++) begin
            if (i == stall_byte) repeat (stall_cyc) @(negedge clk);
            tx_data_i = txb[i]; tx_valid_i = 1;
            while (!tx_ready_o) @(negedge clk);
            @(negedge clk);
            tx_valid_i = 0;
          end
        end
      end
      begin
        if (rx_hold > 0) begin
          rx_ready_i = 0;
          repeat (rx_hold) @(negedge clk);
          rx_ready_i = 1;
        end
      end
    join
    while (!frame_over) @(negedge clk);
    repeat (2) @(negedge clk);
    // R2 / R3: continuous select and exact bit count
    chk(cs_rises == 1 && cs_early == 0, "R2 cs single unbroken window", cs_early, 0);
    chk(rises == exp_bits, "R3 rising edge count", rises, exp_bits);
    chk(idle_bad == 0, "R2 sck idle while deselected", idle_bad, 0);
    chk(hi_bad == 0, "R4 half period", hi_bad, 0);
    mism = 0;
    for (int k = 0; k < exp_bits; k++) begin
      bit e = (md == 2) ? 1'b0 : txb[k/8][7 - (k % 8)];
      if (k >= mosi_bits.size() || mosi_bits[k] != e) mism++;
    end
    chk(mism == 0, md == 2 ? "R6 zero fill" : "R4 mosi msb first", mism, 0);
    if (md == 1) chk(rx_got.size() == 0, "R7 rx dropped", rx_got.size(), 0);
    else begin
      mism = 0;
      for (int i = 0; i < len; i++)
        if (i >= rx_got.size() || rx_got[i] != misob[i]) mism++;
      chk(mism == 0 && rx_got.size() == len, "R5 rx bytes", mism, 0);
    end
    if (md == 2) chk(txr_seen == 0, "R6 no tx handshake", txr_seen, 0);
    chk(dones == 1 && done_bad == 0, "R9 done pulse at release", dones, 1);
    chk(busy_cnt == gp + 1, "R8 gap length", busy_cnt, gp + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1 && sck_o == 0, "R1 pins at reset", int'({cs_n_o, sck_o}), 2);
    chk(!busy_o && !done_o && !rx_valid_o && !tx_ready_o, "R1 flags at reset",
        int'({busy_o, done_o, rx_valid_o, tx_ready_o}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_frame(5, 0, 1, 3, -1, 0, 0, 11);   // memory style access frame
    run_frame(5, 0, 2, 0, 2, 25, 0, 23);   // late tx byte, R2 stall
    run_frame(3, 2, 0, 5, -1, 0, 0, 5);    // R6 receive only
    run_frame(2, 1, 3, 1, -1, 0, 0, 9);    // R7 transmit only
    run_frame(4, 0, 0, 2, -1, 0, 80, 17);  // R5 rx back-pressure
    run_frame(1, 3, 0, 0, -1, 0, 0, 3);    // single byte, mode 3 full duplex
    // R10 zero length
    @(negedge clk);
    start_i = 1; len_i = 0; mode_i = 0;
    #1 chk(busy_o == 0, "R10 busy stays low", int'(busy_o), 0);
    @(negedge clk);
    start_i = 0;
    begin
      int bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (!cs_n_o || busy_o) bad++;
      end
      chk(bad == 0, "R10 select never asserted", bad, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule